// File: doc/BRIEF.md
# Selectable Baud Clock Generator

This block divides a free-running system clock into two related clocks for a serial link: a transmit clock at the baud rate and a receive clock that runs at about the baud rate times an oversample factor. The receive clock is slaved to the transmit clock. It restarts at every transmit edge, and its last half-period inside each transmit half-period is stretched to absorb the remainder. As a result the two clocks never drift apart and both keep exactly the same overall baud rate.

The input clock frequency, the oversample factor and four candidate baud rates are fixed at elaboration. A 2-bit select input picks one of the four rates while the block runs. A new selection is taken only when a full transmit period ends, so no pulse is ever cut short. A phase input sets the idle level of both outputs, and an asynchronous active-low reset returns both outputs to that level.

Top module: `baud_sel_clkgen`

## Requirements
- R1: While rst_n is low, both counters are cleared and tx_clk and rx_clk equal phase; asserting rst_n forces this level immediately, without waiting for a clock edge.
- R2: tx_clk holds each level for exactly floor(CLK_HZ / (2 * baud)) + 1 clk cycles. The +1 is added even when the division is exact.
- R3: Within one tx_clk half-period, rx_clk toggles every floor(CLK_HZ / (2 * baud * OVERSAMPLE)) + 1 clk cycles, counted from the start of that tx half-period.
- R4: rx_clk does not toggle inside a tx half-period when fewer than one full rx half-period of cycles remain before the next tx edge. The last rx half-period is stretched up to that edge.
- R5: Every tx_clk edge is accompanied in the same cycle by an rx_clk edge, and the rx cycle count restarts there.
- R6: The rate used after reset release is the one selected by sel on the first clock edge. Later changes of sel are sampled only at the clk edge that ends a full tx_clk period, which is the edge on which tx_clk returns to the phase level. A change that is reverted before that edge has no effect.
- R7: sel value 0, 1, 2 or 3 selects BAUD0, BAUD1, BAUD2 or BAUD3 respectively.
- R8: Both outputs start at the phase level. Each output is its internal divider state XOR phase, so phase = 1 inverts both waveforms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 1 | Idle and start level of both output clocks |
| sel | input | 2 | Baud rate choice, 0 to 3 |
| rx_clk | output | 1 | Oversampled receive clock |
| tx_clk | output | 1 | Transmit clock at the baud rate |

## Verification
The assertions assume that phase is constant whenever rst_n is high, and that the parameters give a receive half-period no longer than the transmit half-period for every selectable rate. The stimulus changes phase only while reset is held. It also changes sel only on falling clk edges, so the select input is always stable around the rising edge that may sample it. A small configuration with short divisors lets every rate, both phase levels and several select-change instants be swept cycle by cycle against an arithmetic model.

// File: rtl/baud_pkg.sv
package baud_pkg;

   localparam int NUM_RATES = 4;

   // Half-period length in system clocks; one extra cycle always added.
   function automatic int half_cycles(int clk_hz, int rate_hz);
      return clk_hz / (2 * rate_hz) + 1;
   endfunction

   function automatic int max4(int a, int b, int c, int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/baud_rate_table.sv
module baud_rate_table
   import baud_pkg::*;
#(
   parameter int CLK_HZ     = 50_000_000,
   parameter int OVERSAMPLE = 16,
   parameter int BAUD0      = 9600,
   parameter int BAUD1      = 38400,
   parameter int BAUD2      = 57600,
   parameter int BAUD3      = 115200,
   parameter int CW         = 13
) (
   input  logic [1:0]    sel,
   output logic [CW-1:0] tx_half,
   output logic [CW-1:0] rx_half
);

   localparam int RATES [NUM_RATES] = '{BAUD0, BAUD1, BAUD2, BAUD3};

   logic [CW-1:0] tx_tab [NUM_RATES];
   logic [CW-1:0] rx_tab [NUM_RATES];

   for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
      localparam int TXH = half_cycles(CLK_HZ, RATES[i]);
      localparam int RXH = half_cycles(CLK_HZ, RATES[i] * OVERSAMPLE);
      assign tx_tab[i] = CW'(TXH);
      assign rx_tab[i] = CW'(RXH);

      initial begin
         assert (RATES[i] > 0)
            else $error("baud_rate_table: rate %0d must be positive", i);
         assert (RXH <= TXH)
            else $error("baud_rate_table: rx half longer than tx half for rate %0d", i);
         assert (TXH < (1 << CW))
            else $error("baud_rate_table: counter width too small for rate %0d", i);
      end
   end

   assign tx_half = tx_tab[sel];
   assign rx_half = rx_tab[sel];

   initial begin
      assert (OVERSAMPLE >= 1)
         else $error("baud_rate_table: OVERSAMPLE must be at least 1");
   end

endmodule

// File: rtl/baud_tx_div.sv
module baud_tx_div #(
   parameter int CW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] tx_half,
   output logic [CW-1:0] tcnt,
   output logic          tx_bit,
   output logic          tx_end
);

   assign tx_end = (tcnt == tx_half - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt   <= '0;
         tx_bit <= 1'b0;
      end else if (tx_end) begin
         tcnt   <= '0;
         tx_bit <= ~tx_bit;
      end else begin
         tcnt   <= tcnt + CW'(1);
      end
   end

   // R2: the count never leaves the current half-period window
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tcnt < tx_half);

   // R2: a transmit edge only follows the last cycle of a half-period
   p_tx_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_bit != $past(tx_bit)) |-> ($past(tcnt) == $past(tx_half) - CW'(1)));

endmodule

// File: rtl/baud_rx_div.sv
module baud_rx_div #(
   parameter int CW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] tcnt,
   input  logic [CW-1:0] tx_half,
   input  logic [CW-1:0] rx_half,
   input  logic          tx_end,
   input  logic          tx_bit,
   output logic          rx_bit
);

   logic [CW-1:0] rcnt;
   logic [CW:0]   remain;
   logic          fits;
   logic          at_last;

   // cycles left in this tx half after the current one
   assign remain  = (CW+1)'(tx_half) - (CW+1)'(tcnt) - (CW+1)'(1);
   assign fits    = (remain >= (CW+1)'(rx_half));
   assign at_last = (rcnt == rx_half - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt   <= '0;
         rx_bit <= 1'b0;
      end else if (tx_end) begin
         rcnt   <= '0;
         rx_bit <= ~rx_bit;
      end else if (at_last) begin
         if (fits) begin
            rcnt   <= '0;
            rx_bit <= ~rx_bit;
         end
      end else begin
         rcnt   <= rcnt + CW'(1);
      end
   end

   // R5: every transmit edge carries a receive edge
   p_rx_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_bit != $past(tx_bit)) |-> (rx_bit != $past(rx_bit)));

   // R3: an edge inside a tx half only after a full rx half-period
   p_rx_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_bit != $past(rx_bit)) && !$past(tx_end))
         |-> ($past(rcnt) == $past(rx_half) - CW'(1)));

   // R4: no inner edge once less than one rx half-period remains
   p_rx_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_bit != $past(rx_bit)) && !$past(tx_end))
         |-> ($past(tx_half) - $past(tcnt) > $past(rx_half)));

endmodule

// File: rtl/baud_sel_clkgen.sv
module baud_sel_clkgen
   import baud_pkg::*;
#(
   parameter int CLK_HZ     = 50_000_000,
   parameter int OVERSAMPLE = 16,
   parameter int BAUD0      = 9600,
   parameter int BAUD1      = 38400,
   parameter int BAUD2      = 57600,
   parameter int BAUD3      = 115200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       phase,
   input  logic [1:0] sel,
   output logic       rx_clk,
   output logic       tx_clk
);

   localparam int TX_MAX = max4(half_cycles(CLK_HZ, BAUD0), half_cycles(CLK_HZ, BAUD1),
                                half_cycles(CLK_HZ, BAUD2), half_cycles(CLK_HZ, BAUD3));
   localparam int CW     = $clog2(TX_MAX + 1);

   logic          armed_q;
   logic [1:0]    asel_q;
   logic [1:0]    sel_eff;
   logic [CW-1:0] tx_half;
   logic [CW-1:0] rx_half;
   logic [CW-1:0] tcnt;
   logic          tx_bit;
   logic          tx_end;
   logic          rx_bit;
   logic          period_end;

   // first cycle after reset runs on the live select
   assign sel_eff    = armed_q ? asel_q : sel;
   assign period_end = tx_end & tx_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         asel_q  <= '0;
      end else if (!armed_q || period_end) begin
         armed_q <= 1'b1;
         asel_q  <= sel;
      end
   end

   baud_rate_table #(
      .CLK_HZ(CLK_HZ), .OVERSAMPLE(OVERSAMPLE),
      .BAUD0(BAUD0), .BAUD1(BAUD1), .BAUD2(BAUD2), .BAUD3(BAUD3), .CW(CW)
   ) u_table (
      .sel(sel_eff), .tx_half(tx_half), .rx_half(rx_half)
   );

   baud_tx_div #(.CW(CW)) u_tx (
      .clk(clk), .rst_n(rst_n), .tx_half(tx_half),
      .tcnt(tcnt), .tx_bit(tx_bit), .tx_end(tx_end)
   );

   baud_rx_div #(.CW(CW)) u_rx (
      .clk(clk), .rst_n(rst_n), .tcnt(tcnt), .tx_half(tx_half),
      .rx_half(rx_half), .tx_end(tx_end), .tx_bit(tx_bit), .rx_bit(rx_bit)
   );

   assign tx_clk = tx_bit ^ phase;
   assign rx_clk = rx_bit ^ phase;

   // R6: the held selection moves only at a full transmit period boundary
   p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $past(armed_q) && (asel_q != $past(asel_q))) |-> $past(period_end));

   // R6: a new period always starts from a cleared count
   p_sel_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(period_end) |-> (tcnt == '0));

endmodule

// File: tb/baud_sel_clkgen_tb.sv
`timescale 1ns/100ps
module baud_sel_clkgen_tb;

   localparam int CLK_HZ = 1000;
   localparam int OVS    = 4;
   localparam int BR [4] = '{100, 50, 70, 25};

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       phase = 1'b0;
   logic [1:0] sel   = 2'd0;
   logic       rx_clk;
   logic       tx_clk;
   int         checks = 0;
   int         errors = 0;
   logic       prev_rx;

   always #2.5 clk = ~clk;

   baud_sel_clkgen #(
      .CLK_HZ(CLK_HZ), .OVERSAMPLE(OVS),
      .BAUD0(BR[0]), .BAUD1(BR[1]), .BAUD2(BR[2]), .BAUD3(BR[3])
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .phase(phase), .sel(sel),
      .rx_clk(rx_clk), .tx_clk(tx_clk)
   );

   function automatic int txh(int s);
      return CLK_HZ / (2 * BR[s]) + 1;
   endfunction

   function automatic int rxh(int s);
      return CLK_HZ / (2 * BR[s] * OVS) + 1;
   endfunction

   function automatic logic exp_tx(int s, int p);
      return logic'((p / txh(s)) % 2);
   endfunction

   function automatic logic exp_rx(int s, int p);
      int n, h, t, k;
      n = txh(s) / rxh(s);
      h = p / txh(s);
      t = p % txh(s);
      k = t / rxh(s);
      if (k > n - 1) k = n - 1;
      return logic'((h * n + k) % 2);
   endfunction

   task automatic check_bit(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // compare both outputs with the model at position p of rate s
   task automatic check_pos(int s, int p, string tag);
      int t, n;
      t = p % txh(s);
      n = txh(s) / rxh(s);
      check_bit({tag, " R2 R7 tx"}, tx_clk, exp_tx(s, p) ^ phase);
      if (t >= n * rxh(s))
         check_bit({tag, " R4 rx"}, rx_clk, exp_rx(s, p) ^ phase);
      else
         check_bit({tag, " R3 rx"}, rx_clk, exp_rx(s, p) ^ phase);
      if (p > 0 && t == 0)
         check_bit({tag, " R5 rx edge at tx edge"}, logic'(rx_clk != prev_rx), 1'b1);
      prev_rx = rx_clk;
   endtask

   task automatic start(int s, logic ph);
      rst_n = 1'b0;
      sel   = 2'(s);
      phase = ph;
      @(negedge clk);
      @(negedge clk);
      check_bit("R1 R8 reset tx", tx_clk, ph);
      check_bit("R1 R8 reset rx", rx_clk, ph);
      rst_n   = 1'b1;
      prev_rx = rx_clk;
   endtask

   task automatic run_fixed(int s, logic ph);
      int total;
      total = 6 * txh(s);
      start(s, ph);
      for (int p = 0; p < total; p++) begin
         if (p > 0) @(negedge clk);
         check_pos(s, p, "fixed");
      end
      // last position lies in an odd tx half: tx is away from phase
      check_bit("R1 pre-reset tx away from phase", tx_clk, ~ph);
      #1 rst_n = 1'b0;
      #0.5;
      check_bit("R1 async reset tx", tx_clk, ph);
      check_bit("R1 async reset rx", rx_clk, ph);
   endtask

   task automatic run_switch(int s0, int s1, int c, bit glitch);
      int b, total;
      b     = 2 * txh(s0);
      total = b + 4 * txh(s1);
      start(s0, 1'b0);
      for (int p = 0; p < total; p++) begin
         if (p > 0) @(negedge clk);
         if (glitch || p < b) check_pos(s0, p, "R6 switch");
         else                 check_pos(s1, p - b, "R6 switch");
         if (p == c) sel = 2'(s1);
         if (glitch && p == c + 1) sel = 2'(s0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int s = 0; s < 4; s++) begin
         for (int ph = 0; ph < 2; ph++) run_fixed(s, logic'(ph));
      end
      run_switch(0, 3, 1, 1'b0);
      run_switch(0, 3, txh(0) + 2, 1'b0);
      run_switch(3, 2, 3, 1'b0);
      run_switch(2, 1, 2 * txh(2) - 2, 1'b0);
      run_switch(1, 2, 2, 1'b1);
      run_switch(1, 0, txh(1) + 1, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule